// File: doc/BRIEF.md
# Watchdog Timer with Keyed Control Access

This block is a watchdog for a small microcontroller core. A free-running tick enable, derived from a fixed-rate oscillator and already brought into the system clock domain, drives a prescaler. The prescaler divides by a power of two between 1 and 32768. Its output advances an 8-bit timeout counter. If software fails to feed the watchdog before that counter wraps, the block raises a reset request for a fixed number of system clocks. It also sets a sticky cause flag, which survives the reset that the request produces.

Software reaches the block over a byte-wide register bus with an address, write data, a write strobe, a read strobe and registered read data. There are three registers. The access-key register sits at F7h. It guards the control register against stray writes: a control write takes effect only directly after the key bytes 55h, AAh and 5Ah. The control register sits at B6h. It holds the cause flag (bit 7), the run enable (bit 5) and the divider select (bits 3:0). The refresh register sits at B7h and clears the count when 55h is written to it. A static fuse input can hold the watchdog off whatever software does.

Two resets come in. `rst` is the external or power-on reset and clears everything. `sys_rst` is the chip-wide reset from any source, including this watchdog. It clears everything except the cause flag.

Top module: `wdog_ctrl`

## Requirements
- R1: After `rst`, a read of the control register (B6h) returns 04h: flag 0, enable 0, divider select 4. Reads of the access-key register (F7h) and the refresh register (B7h) return 00h, and `wdt_rst_req` is low.
- R2: A control-register write takes effect only directly after the key bytes 55h, AAh, 5Ah written to F7h in that order. In that case bit 5 sets the enable and bits 3:0 set the divider select. Bits 6 and 4 always read as 0.
- R3: One completed key sequence grants exactly one control write. A second control write without a new sequence leaves the register unchanged.
- R4: A key byte that does not match the expected next byte restarts the sequence check. A 55h that breaks the sequence counts as a new first byte.
- R5: When running with divider select m, the reset request rises exactly 256·2^m tick pulses after the count was last cleared.
- R6: Writing 55h to B7h clears the prescaler and the timeout counter. Any other byte written there has no effect on the timeout schedule.
- R7: Each timeout holds `wdt_rst_req` high for exactly PULSE_CYCLES system clocks (default 4).
- R8: A timeout sets the cause flag (control bit 7). `sys_rst` returns the enable and divider select to their reset values but leaves the flag set.
- R9: The flag is cleared by an unlocked control write with bit 7 at 0, or by `rst`. Writing 1 to bit 7 does not change it.
- R10: The watchdog runs only while the enable is 1 and `fuse_off` is 0. While it is not running, the prescaler and the counter are held at zero, so each restart begins a full period.
- R11: The prescaler and the counter advance only on clocks where `tick` is high.
- R12: `rdata` is loaded on the clock edge where `rd` is high and holds its value on clocks without `rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | External or power-on reset, synchronous, active high; clears everything |
| sys_rst | input | 1 | Chip-wide reset from any source, synchronous, active high; keeps the cause flag |
| tick | input | 1 | One-clock enable pulse at the fixed oscillator rate |
| fuse_off | input | 1 | Static fuse; 1 forces the watchdog off |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| wdt_rst_req | output | 1 | Reset request, held high for PULSE_CYCLES clocks |

## Verification
The bound checker covers the behaviour that holds on every cycle:
- A locked control write leaves the control fields stable.
- A refresh key and the fuse both leave the counter at zero on the next cycle.
- Every request pulse is exactly PULSE_CYCLES long and comes with the flag set.
- The flag survives `sys_rst`.

Only the directed scenarios can show the things that depend on history:
- The exact timeout distance for several divider selects.
- Byte orders in the key sequence that restart it.
- The one-shot nature of an unlock.
- That a wrong refresh byte does not shift the timeout schedule.
- That disabling the watchdog or stalling the tick restarts or freezes the period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int SEL_W    = 4;
    localparam int FLAG_BIT = 7;
    localparam int EN_BIT   = 5;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{en: 1'b0, sel: 4'd4};

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_ONE  = 2'd1,
        UL_TWO  = 2'd2,
        UL_OPEN = 2'd3
    } unlock_st_e;

    function automatic logic [7:0] pack_ctl(input logic flag, input ctl_t c);
        logic [7:0] v;
        v            = '0;
        v[FLAG_BIT]  = flag;
        v[EN_BIT]    = c.en;
        v[SEL_W-1:0] = c.sel;
        return v;
    endfunction

endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
    import wdog_pkg::*;
#(
    parameter logic [7:0] KEY0 = 8'h55,
    parameter logic [7:0] KEY1 = 8'hAA,
    parameter logic [7:0] KEY2 = 8'h5A
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       ctl_wr,
    output logic       unlocked
);

    unlock_st_e st_q, st_d;
    logic       is_first;

    assign is_first = (key_byte == KEY0);

    always_comb begin
        st_d = st_q;
        if (key_wr) begin
            unique case (st_q)
                UL_IDLE: st_d = is_first ? UL_ONE : UL_IDLE;
                UL_ONE:  st_d = (key_byte == KEY1) ? UL_TWO :
                                (is_first ? UL_ONE : UL_IDLE);
                UL_TWO:  st_d = (key_byte == KEY2) ? UL_OPEN :
                                (is_first ? UL_ONE : UL_IDLE);
                UL_OPEN: st_d = is_first ? UL_ONE : UL_IDLE;
                default: st_d = UL_IDLE;
            endcase
        end else if (ctl_wr && st_q == UL_OPEN) begin
            st_d = UL_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= UL_IDLE;
        else     st_q <= st_d;
    end

    assign unlocked = (st_q == UL_OPEN);

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             clear,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             step
);

    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign mask = ~({PRE_W{1'b1}} << sel);
    assign step = tick && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (clear)     pre_q <= '0;
        else if (tick) pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/wdog_timeout.sv
module wdog_timeout #(
    parameter int CNT_W        = 8,
    parameter int PULSE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic             overflow,
    output logic [CNT_W-1:0] cnt,
    output logic             req
);

    localparam int PW = $clog2(PULSE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    pulse_q;

    assign overflow = step && (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (clear)     cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                 pulse_q <= '0;
        else if (overflow)       pulse_q <= PW'(PULSE_CYCLES);
        else if (pulse_q != '0)  pulse_q <= pulse_q - 1'b1;
    end

    assign cnt = cnt_q;
    assign req = (pulse_q != '0);

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int         CNT_W        = 8,
    parameter int         PULSE_CYCLES = 4,
    parameter logic [7:0] KEY_ADDR     = 8'hF7,
    parameter logic [7:0] CTL_ADDR     = 8'hB6,
    parameter logic [7:0] RFR_ADDR     = 8'hB7,
    parameter logic [7:0] REFRESH_KEY  = 8'h55
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sys_rst,
    input  logic       tick,
    input  logic       fuse_off,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       wr,
    input  logic       rd,
    output logic [7:0] rdata,
    output logic       wdt_rst_req
);

    logic             blk_rst;
    logic             key_wr, ctl_wr, rfr_wr, refresh_hit;
    logic             unlocked;
    logic             ctl_take;
    ctl_t             ctl_q;
    logic             flag_q;
    logic             run;
    logic             cnt_clear;
    logic             step;
    logic             overflow;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       rd_mux;

    assign blk_rst     = rst | sys_rst;
    assign key_wr      = wr && (addr == KEY_ADDR);
    assign ctl_wr      = wr && (addr == CTL_ADDR);
    assign rfr_wr      = wr && (addr == RFR_ADDR);
    assign refresh_hit = rfr_wr && (wdata == REFRESH_KEY);
    assign ctl_take    = ctl_wr && unlocked;

    wdog_unlock u_unlock (
        .clk      (clk),
        .rst      (blk_rst),
        .key_wr   (key_wr),
        .key_byte (wdata),
        .ctl_wr   (ctl_wr),
        .unlocked (unlocked)
    );

    always_ff @(posedge clk) begin
        if (blk_rst) begin
            ctl_q <= CTL_RESET;
        end else if (ctl_take) begin
            ctl_q.en  <= wdata[EN_BIT];
            ctl_q.sel <= wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                              flag_q <= 1'b0;
        else if (overflow)                    flag_q <= 1'b1;
        else if (ctl_take && !wdata[FLAG_BIT]) flag_q <= 1'b0;
    end

    assign run       = ctl_q.en && !fuse_off;
    assign cnt_clear = blk_rst || !run || refresh_hit;

    wdog_prescaler u_pre (
        .clk   (clk),
        .clear (cnt_clear),
        .tick  (tick),
        .sel   (ctl_q.sel),
        .step  (step)
    );

    wdog_timeout #(
        .CNT_W        (CNT_W),
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_tmo (
        .clk      (clk),
        .rst      (blk_rst),
        .clear    (cnt_clear),
        .step     (step),
        .overflow (overflow),
        .cnt      (cnt),
        .req      (wdt_rst_req)
    );

    always_comb begin
        if (addr == CTL_ADDR) rd_mux = pack_ctl(flag_q, ctl_q);
        else                  rd_mux = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (blk_rst) rdata <= 8'h00;
        else if (rd) rdata <= rd_mux;
    end

endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk
    import wdog_pkg::*;
#(
    parameter int         CNT_W        = 8,
    parameter int         PULSE_CYCLES = 4,
    parameter logic [7:0] CTL_ADDR     = 8'hB6,
    parameter logic [7:0] RFR_ADDR     = 8'hB7,
    parameter logic [7:0] REFRESH_KEY  = 8'h55
) (
    input logic             clk,
    input logic             rst,
    input logic             sys_rst,
    input logic             fuse_off,
    input logic [7:0]       addr,
    input logic [7:0]       wdata,
    input logic             wr,
    input logic             req,
    input logic             flag,
    input logic             unlocked,
    input logic             ctl_en,
    input logic [SEL_W-1:0] ctl_sel,
    input logic [CNT_W-1:0] cnt
);

    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || sys_rst) hi_cnt <= '0;
        else if (req)       hi_cnt <= hi_cnt + 1'b1;
        else                hi_cnt <= '0;
    end

    // R2, R3: a control write with no open unlock leaves the fields alone
    a_r2_locked_write: assert property (@(posedge clk) disable iff (rst || sys_rst)
        (wr && addr == CTL_ADDR && !unlocked) |=> ($stable(ctl_en) && $stable(ctl_sel)));

    // R6: the refresh key zeroes the counter
    a_r6_refresh_clears: assert property (@(posedge clk) disable iff (rst || sys_rst)
        (wr && addr == RFR_ADDR && wdata == REFRESH_KEY) |=> (cnt == '0));

    // R10: the fuse holds the counter at zero
    a_r10_fuse_holds: assert property (@(posedge clk) disable iff (rst || sys_rst)
        fuse_off |=> (cnt == '0));

    // R7: every pulse lasts exactly PULSE_CYCLES clocks
    a_r7_pulse_width: assert property (@(posedge clk) disable iff (rst || sys_rst)
        (!req && hi_cnt != '0) |-> (hi_cnt == 16'(PULSE_CYCLES)));

    // R8: a request comes with the cause flag set
    a_r8_flag_on_req: assert property (@(posedge clk) disable iff (rst || sys_rst)
        $rose(req) |-> flag);

    // R8: the chip-wide reset keeps the flag
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (sys_rst && flag) |=> flag);

endmodule

bind wdog_ctrl wdog_ctrl_chk #(
    .CNT_W        (CNT_W),
    .PULSE_CYCLES (PULSE_CYCLES),
    .CTL_ADDR     (CTL_ADDR),
    .RFR_ADDR     (RFR_ADDR),
    .REFRESH_KEY  (REFRESH_KEY)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sys_rst  (sys_rst),
    .fuse_off (fuse_off),
    .addr     (addr),
    .wdata    (wdata),
    .wr       (wr),
    .req      (wdt_rst_req),
    .flag     (flag_q),
    .unlocked (unlocked),
    .ctl_en   (ctl_q.en),
    .ctl_sel  (ctl_q.sel),
    .cnt      (cnt)
);

// File: tb/wdog_ctrl_tb.sv
`timescale 1ns/1ps
module wdog_ctrl_tb;

    localparam logic [7:0] A_KEY = 8'hF7;
    localparam logic [7:0] A_CTL = 8'hB6;
    localparam logic [7:0] A_RFR = 8'hB7;

    logic       clk = 1'b0;
    logic       rst = 1'b1, sys_rst = 1'b0, tick = 1'b1, fuse_off = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] rdata;
    logic       req;

    int errs = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wdog_ctrl u_dut (
        .clk(clk), .rst(rst), .sys_rst(sys_rst), .tick(tick), .fuse_off(fuse_off),
        .addr(addr), .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata), .wdt_rst_req(req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // every bus task is entered at a negedge and consumes exactly one rising edge
    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic unlock();
        wr_reg(A_KEY, 8'h55); wr_reg(A_KEY, 8'hAA); wr_reg(A_KEY, 8'h5A);
    endtask

    task automatic cfg(input logic [7:0] v);
        unlock(); wr_reg(A_CTL, v);
    endtask

    // called right after the edge that cleared or started the count
    task automatic expect_timeout(input string tag, input int n);
        repeat (n - 1) @(negedge clk);
        chk({tag, " req low one edge early"}, {7'd0, req}, 8'h00);
        @(negedge clk);
        chk({tag, " req high at timeout"}, {7'd0, req}, 8'h01);
    endtask

    task automatic pulse_sys_rst();
        sys_rst = 1'b1; @(negedge clk); sys_rst = 1'b0;
    endtask

    task automatic pulse_rst();
        rst = 1'b1; @(negedge clk); rst = 1'b0;
    endtask

    task automatic quiet(input string tag, input int n);
        int highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (req) highs++;
        end
        chk(tag, 8'(highs), 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 req after reset", {7'd0, req}, 8'h00);
        rd_reg(A_CTL, d); chk("R1 control reset value", d, 8'h04);
        rd_reg(A_KEY, d); chk("R1 access key reads 00", d, 8'h00);
        rd_reg(A_RFR, d); chk("R1 refresh key reads 00", d, 8'h00);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        wr_reg(A_CTL, 8'h2F);
        rd_reg(A_CTL, d); chk("R2 locked write ignored", d, 8'h04);
        cfg(8'h5F);
        rd_reg(A_CTL, d); chk("R2 unlocked write, bits 6/4 read 0", d, 8'h0F);
        wr_reg(A_CTL, 8'h03);
        rd_reg(A_CTL, d); chk("R3 second write after one unlock", d, 8'h0F);
        rd_reg(A_KEY, d);
        addr = A_CTL; @(negedge clk);
        chk("R12 rdata holds without rd", rdata, 8'h00);
    endtask

    task automatic t_restart();
        logic [7:0] d;
        wr_reg(A_KEY, 8'h55); wr_reg(A_KEY, 8'hAA); wr_reg(A_KEY, 8'h00); wr_reg(A_KEY, 8'h5A);
        wr_reg(A_CTL, 8'h07);
        rd_reg(A_CTL, d); chk("R4 broken sequence stays locked", d, 8'h0F);
        wr_reg(A_KEY, 8'h55); wr_reg(A_KEY, 8'h55); wr_reg(A_KEY, 8'hAA); wr_reg(A_KEY, 8'h5A);
        wr_reg(A_CTL, 8'h07);
        rd_reg(A_CTL, d); chk("R4 repeated 55h restarts as first byte", d, 8'h07);
    endtask

    task automatic t_timeout_m0();
        logic [7:0] d;
        cfg(8'h20);
        expect_timeout("R5 m=0", 256);
        repeat (3) @(negedge clk);
        chk("R7 req still high on 4th clock", {7'd0, req}, 8'h01);
        @(negedge clk);
        chk("R7 req low after 4 clocks", {7'd0, req}, 8'h00);
        rd_reg(A_CTL, d); chk("R8 flag set by timeout", d, 8'hA0);
        pulse_sys_rst();
        rd_reg(A_CTL, d); chk("R8 flag survives sys_rst", d, 8'h84);
    endtask

    task automatic t_flag_clear();
        logic [7:0] d;
        cfg(8'h84);
        rd_reg(A_CTL, d); chk("R9 writing 1 to bit 7 keeps flag", d, 8'h84);
        cfg(8'h04);
        rd_reg(A_CTL, d); chk("R9 software clears flag", d, 8'h04);
        cfg(8'h20);
        repeat (260) @(negedge clk);
        pulse_sys_rst();
        rd_reg(A_CTL, d); chk("R9 flag set again", d, 8'h84);
        pulse_rst();
        rd_reg(A_CTL, d); chk("R9 external reset clears flag", d, 8'h04);
    endtask

    task automatic t_refresh();
        cfg(8'h20);
        repeat (99) @(negedge clk);
        wr_reg(A_RFR, 8'h54);
        expect_timeout("R6 wrong refresh byte no effect", 156);
        pulse_sys_rst();
        cfg(8'h20);
        repeat (199) @(negedge clk);
        wr_reg(A_RFR, 8'h55);
        expect_timeout("R6 refresh restarts period", 256);
        pulse_sys_rst(); pulse_rst();
    endtask

    task automatic t_fuse();
        logic [7:0] d;
        fuse_off = 1'b1;
        cfg(8'h20);
        quiet("R10 fuse holds watchdog off", 400);
        rd_reg(A_CTL, d); chk("R10 no flag while fused off", d, 8'h20);
        fuse_off = 1'b0;
        expect_timeout("R10 full period after fuse release", 256);
        pulse_sys_rst();
        cfg(8'h20);
        repeat (199) @(negedge clk);
        cfg(8'h00);
        cfg(8'h20);
        expect_timeout("R10 disable restarts period", 256);
        pulse_sys_rst(); pulse_rst();
    endtask

    task automatic t_prescale();
        cfg(8'h21);
        expect_timeout("R5 m=1", 512);
        pulse_sys_rst();
        cfg(8'h22);
        expect_timeout("R5 m=2", 1024);
        pulse_sys_rst(); pulse_rst();
    endtask

    task automatic t_tick();
        tick = 1'b0;
        cfg(8'h20);
        quiet("R11 no counting without tick", 600);
        tick = 1'b1;
        expect_timeout("R11 counting resumes with tick", 256);
        pulse_sys_rst(); pulse_rst();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_lock();
        t_restart();
        pulse_rst();
        t_timeout_m0();
        t_flag_clear();
        t_refresh();
        t_fuse();
        t_prescale();
        t_tick();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule